// File: doc/BRIEF.md
# Magnetic Stripe Track Decoder

This block turns the raw signals of a magnetic stripe reader head into a stream of ASCII bytes for a display interface. It has three active-low inputs: card-present, serial data and data strobe. The strobe is not used as a clock. It is oversampled by a much faster system clock. The strobe first passes through a two-flop synchronizer, and each high-to-low transition of the synchronized strobe samples the data line once.

A swipe begins with a run of zero bits. Framing starts at the first 1 bit, and that bit is bit 0 of the first character. Bits are grouped into 7-bit characters that arrive least significant bit first. The low 6 bits form the track code and the top bit is parity, which is discarded. Each completed code is offset into the printable ASCII range and presented with a one-cycle write strobe. Removing the card, or applying the synchronous reset, clears the framing state so that the next swipe starts clean.

Top module: `magstripe_track_decoder`

## Requirements
- R1: The strobe input passes through two flip-flops clocked by `clk`. A data bit is sampled only when the synchronized strobe was 1 on one cycle and is 0 on the next. After the strobe input falls for the 7th bit of a character, `wr_en` is high in the third clock cycle and low in the first two.
- R2: The data line is inverted. `data_n` = 0 is logic 1 and `data_n` = 1 is logic 0.
- R3: Zero bits that come before the first 1 bit of a swipe are discarded. The first 1 bit is bit 0 of the first character.
- R4: Each character is 7 bits, received least significant bit first (bit 0 on the wire first). Exactly one write is issued per completed character, in arrival order.
- R5: Bit 6 (parity) has no effect on the byte written.
- R6: `wr_byte` = code + 0x20, where the code is bits 5..0 of the character. Code 0x05 gives 0x25 ('%') and code 0x28 gives 0x48 ('H').
- R7: `wr_en` is a single-cycle pulse. It is never high on two consecutive cycles.
- R8: While the synchronized card-present signal reads no card (`card_n` = 1), strobe edges are ignored. On removal the bit counter and the started flag clear, so a partial character is dropped.
- R9: Synchronous reset `rst` (active high) clears `wr_en`, `wr_byte`, the bit counter and the started flag. A partial character that is in progress when reset is applied is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobe |
| rst | input | 1 | Synchronous reset, active high |
| card_n | input | 1 | Card present, active low |
| data_n | input | 1 | Serial track data, active low |
| strobe_n | input | 1 | Data strobe, active on its falling edge |
| wr_en | output | 1 | One-cycle write request to the display side |
| wr_byte | output | 8 | ASCII byte that goes with `wr_en` |

## Verification
**Directed swipe.** A directed swipe sends the sentinel followed by "HELL0!!!". It checks the exact byte sequence and the three-cycle write latency. A bit-order or inversion fault would turn 'H' and 'L' into different codes, so this case exposes both.

**Parity, removal and reset.** Characters with deliberately wrong parity separate a decoder that masks bit 6 from one that leaks it. A card removed mid-character, and a reset applied mid-character, each show whether stale bits would shift into the next swipe. Strobes sent while no card is present must produce no write.

**Random swipes.** Random swipes vary the leading-zero count, the strobe phase lengths and the codes. They check that framing starts at the first 1 bit whatever the timing.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int MST_CHAR_BITS = 7;
  localparam int MST_CODE_BITS = 6;
  localparam int MST_SYNC_STAGES = 2;
  localparam logic [7:0] MST_ASCII_OFFSET = 8'h20;

  // Track code to display byte: plain offset into the printable range.
  function automatic logic [7:0] mst_code_to_ascii(input logic [MST_CODE_BITS-1:0] code);
    return 8'(code) + MST_ASCII_OFFSET;
  endfunction
endpackage

// File: rtl/mst_sync.sv
module mst_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mst_edge.sv
module mst_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b1;
    else     level_q <= level;
  end

  assign fall = level_q & ~level;
endmodule

// File: rtl/mst_framer.sv
module mst_framer #(
  parameter int CHAR_BITS = 7,
  parameter int CODE_BITS = 6,
  localparam int CNT_W = $clog2(CHAR_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 sample,
  input  logic                 bit_in,
  output logic                 started,
  output logic [CNT_W-1:0]     bit_cnt,
  output logic                 char_done,
  output logic [CODE_BITS-1:0] char_code,
  output logic                 char_parity
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_BITS - 1);

  logic [CHAR_BITS-1:0] shreg;
  logic [CHAR_BITS-1:0] word_next;

  assign word_next = {bit_in, shreg[CHAR_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      started <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (sample) begin
      if (!started) begin
        if (bit_in) begin
          started <= 1'b1;
          bit_cnt <= CNT_W'(1);
          shreg   <= word_next;
        end
      end else begin
        shreg   <= word_next;
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CNT_W'(1);
      end
    end
  end

  assign char_done   = enable && sample && started && (bit_cnt == LAST);
  assign char_code   = word_next[CODE_BITS-1:0];
  assign char_parity = word_next[CHAR_BITS-1];
endmodule

// File: rtl/magstripe_track_decoder.sv
module magstripe_track_decoder
  import mst_pkg::*;
#(
  parameter int CHAR_BITS = MST_CHAR_BITS,
  parameter int CODE_BITS = MST_CODE_BITS,
  parameter int SYNC_STAGES = MST_SYNC_STAGES,
  localparam int CNT_W = $clog2(CHAR_BITS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       card_n,
  input  logic       data_n,
  input  logic       strobe_n,
  output logic       wr_en,
  output logic [7:0] wr_byte
);
  logic card_sync_n;
  logic strobe_sync;
  logic card_present;
  logic sample_evt;
  logic data_bit;
  logic started;
  logic [CNT_W-1:0] bit_cnt;
  logic char_done;
  logic [CODE_BITS-1:0] char_code;
  logic char_parity;

  mst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_card_sync (
    .clk(clk), .rst(rst), .d_async(card_n), .q_sync(card_sync_n)
  );

  mst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strobe_sync (
    .clk(clk), .rst(rst), .d_async(strobe_n), .q_sync(strobe_sync)
  );

  mst_edge u_edge (
    .clk(clk), .rst(rst), .level(strobe_sync), .fall(sample_evt)
  );

  assign card_present = ~card_sync_n;
  assign data_bit     = ~data_n;

  mst_framer #(.CHAR_BITS(CHAR_BITS), .CODE_BITS(CODE_BITS)) u_framer (
    .clk(clk), .rst(rst), .enable(card_present), .sample(sample_evt),
    .bit_in(data_bit), .started(started), .bit_cnt(bit_cnt),
    .char_done(char_done), .char_code(char_code), .char_parity(char_parity)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_byte <= 8'h00;
    end else begin
      wr_en <= char_done;
      if (char_done) wr_byte <= mst_code_to_ascii(char_code);
    end
  end
endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
  parameter int CNT_W = 3,
  parameter int CHAR_BITS = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             card_present,
  input logic             strobe_sync,
  input logic             sample_evt,
  input logic             data_bit,
  input logic             started,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             char_parity,
  input logic             wr_en,
  input logic [7:0]       wr_byte
);
  AST_SAMPLE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    sample_evt |-> (!strobe_sync && $past(strobe_sync))); // R1
  AST_START_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    $rose(started) |-> $past(sample_evt && data_bit && card_present)); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_cnt < CNT_W'(CHAR_BITS)); // R4
  AST_PRINTABLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_byte >= 8'h20 && wr_byte <= 8'h5F)); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R7
  AST_NO_CARD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !card_present |=> (!started && !wr_en)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_en && !started && bit_cnt == '0)); // R9
  AST_PARITY_KNOWN: assert property (@(posedge clk) disable iff (rst)
    sample_evt |-> !$isunknown(char_parity)); // R5
endmodule

bind magstripe_track_decoder mst_checker #(.CNT_W(CNT_W), .CHAR_BITS(CHAR_BITS)) u_chk (
  .clk(clk), .rst(rst), .card_present(card_present), .strobe_sync(strobe_sync),
  .sample_evt(sample_evt), .data_bit(data_bit), .started(started),
  .bit_cnt(bit_cnt), .char_parity(char_parity), .wr_en(wr_en), .wr_byte(wr_byte)
);

// File: tb/tb_magstripe_track_decoder.sv
`timescale 1ns/1ps
module tb_magstripe_track_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic card_n = 1'b1;
  logic data_n = 1'b1;
  logic strobe_n = 1'b1;
  logic wr_en;
  logic [7:0] wr_byte;

  int checks = 0;
  int fails = 0;
  int dbl_pulse = 0;
  bit done = 1'b0;
  bit prev_wr = 1'b0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  magstripe_track_decoder dut (
    .clk(clk), .rst(rst), .card_n(card_n), .data_n(data_n),
    .strobe_n(strobe_n), .wr_en(wr_en), .wr_byte(wr_byte)
  );

  always @(negedge clk) begin
    if (wr_en) got.push_back(wr_byte);
    if (wr_en && prev_wr) dbl_pulse++;
    prev_wr = wr_en;
  end

  function automatic logic [7:0] exp_ascii(input int code);
    return 8'(32 + (code % 64));
  endfunction

  function automatic bit odd_par(input int code);
    return ~^code[5:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_bit(input bit b, input int ph, input bit lat);
    @(negedge clk);
    data_n = ~b;
    repeat (ph) @(negedge clk);
    strobe_n = 1'b0;
    if (lat) begin
      @(negedge clk); check("R1 lat c1", wr_en, 0);
      @(negedge clk); check("R1 lat c2", wr_en, 0);
      @(negedge clk); check("R1 lat c3", wr_en, 1);
      repeat (ph - 3) @(negedge clk);
    end else repeat (ph) @(negedge clk);
    strobe_n = 1'b1;
  endtask

  task automatic send_char(input int code, input bit par, input int ph, input bit lat);
    for (int i = 0; i < 6; i++) send_bit(code[i], ph, 1'b0);
    send_bit(par, ph, lat);
  endtask

  task automatic send_zeros(input int n, input int ph);
    for (int i = 0; i < n; i++) send_bit(1'b0, ph, 1'b0);
  endtask

  task automatic compare(input string req);
    check({req, " count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(req, got[i], exp_q[i]);
    got.delete();
    exp_q.delete();
  endtask

  initial begin
    automatic int msg[8] = '{8'h28, 8'h25, 8'h2C, 8'h2C, 8'h10, 8'h01, 8'h01, 8'h01};
    automatic int seed = $urandom(32'h5A17);
    repeat (5) @(negedge clk);
    check("R9 reset wr_en", wr_en, 0);
    check("R9 reset wr_byte", wr_byte, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Directed swipe: sentinel then HELL0!!! (R2 R3 R4 R6 R1)
    card_n = 1'b0;
    repeat (4) @(negedge clk);
    send_zeros(6, 5);
    send_char(5, 1'b1, 5, 1'b1);
    exp_q.push_back(8'h25);
    foreach (msg[i]) begin
      send_char(msg[i], odd_par(msg[i]), 5, 1'b0);
      exp_q.push_back(exp_ascii(msg[i]));
    end
    repeat (10) @(negedge clk);
    compare("R4 R6 directed");

    // Wrong parity must not change the byte (R5)
    send_char(6'h2A, ~odd_par(6'h2A), 4, 1'b0); exp_q.push_back(8'h4A);
    send_char(6'h3F, 1'b1, 4, 1'b0);            exp_q.push_back(8'h5F);
    send_char(6'h00, 1'b1, 4, 1'b0);            exp_q.push_back(8'h20);
    repeat (10) @(negedge clk);
    compare("R5 parity");

    // Card removal mid-character, strobes while absent (R8)
    for (int i = 0; i < 3; i++) send_bit(1'b1, 4, 1'b0);
    card_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 4, 1'b0);
    repeat (10) @(negedge clk);
    check("R8 no write while absent", got.size(), 0);
    card_n = 1'b0;
    repeat (4) @(negedge clk);
    send_zeros(3, 4);
    send_char(6'h21, odd_par(6'h21), 4, 1'b0); exp_q.push_back(8'h41);
    repeat (10) @(negedge clk);
    compare("R8 fresh swipe");

    // Reset mid-character (R9)
    for (int i = 0; i < 4; i++) send_bit(1'b1, 4, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    send_zeros(2, 4);
    send_char(6'h13, odd_par(6'h13), 4, 1'b0); exp_q.push_back(8'h33);
    repeat (10) @(negedge clk);
    compare("R9 after reset");

    // Random swipes (R2 R3 R4 R6)
    for (int s = 0; s < 6; s++) begin
      card_n = 1'b1;
      repeat (8) @(negedge clk);
      card_n = 1'b0;
      repeat (4) @(negedge clk);
      send_zeros(1 + ($urandom % 10), 3 + ($urandom % 6));
      for (int c = 0; c < 8; c++) begin
        automatic int code = (c == 0) ? 5 : ($urandom % 64);
        automatic int ph = 3 + ($urandom % 7);
        send_char(code | ((c == 0) ? 0 : 1), $urandom % 2, ph, 1'b0);
        exp_q.push_back(exp_ascii(code | ((c == 0) ? 0 : 1)));
      end
      repeat (10) @(negedge clk);
      compare("R3 R4 random");
    end

    check("R7 single-cycle pulse", dbl_pulse, 0);
    if (seed == -1) $display("seed");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule